// File: doc/BRIEF.md
# Register-Programmed SPI Shift Engine

This block is an SPI master that software drives through six 32-bit registers on a simple single-cycle read/write bus. To move a word, software loads the transmit register and then writes one command word. That word starts the shift, picks one of three chip selects, sets the bit count (1 to 32) and says whether the chip select is released when the shift ends. Bit 31 of the command register reads back as a busy flag and clears itself when the last bit is done. When the release flag is clear, the chip select stays low after the shift. This lets one frame span many words.

The serial clock runs in a single fixed mode. SCK idles low. The outgoing data changes on the falling edge and the incoming data is sampled on the rising edge. A 6-bit divider sets the SCK rate from the system clock. A pin-state register gives the levels the pins take while nothing is shifting.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset the pin-state register reads 0x0007_0000 and every other register reads 0. The pins show cs_n_o = 3'b111, sck_o = 0 and mosi_o = 0.
- R2: The registers sit at these byte offsets: 0x00 gate (bit 0 enables starts), 0x04 rate (bits [5:0] are the divider D), 0x08 pin-state, 0x10 transmit, 0x14 command and 0x18 receive. Each writable register reads back its last written value. An unmapped offset reads 0.
- R3: The command word has this layout: bit 31 is go, bits 28, 29 and 30 select chip select 0, 1 and 2, bit 26 is release, and bits [5:0] are the count. Writing the command word with go set, while the gate bit is 1 and the block is idle, starts a shift on the next clock edge.
- R4: Command bit 31 reads 1 for exactly 2·N·(D+1) clock cycles after the starting write, then reads 0 again. Here N is the bit count and D is the divider.
- R5: A count field of 0, or of any value above 32, shifts 32 bits.
- R6: The transmit word is right-aligned, and bit N-1 goes out first. mosi_o changes only at the start of the shift and on falling SCK edges. The engine's SCK is low whenever it is idle.
- R7: miso_i is sampled on each rising SCK edge and enters the receive register at bit 0. After N bits, the first bit received is at bit N-1 and the bits above N-1 are 0.
- R8: While shifting, only the selected chip select is driven low. If several select bits are set, the lowest-numbered one wins. With release = 1 the chip select goes high when the shift ends. With release = 0 it stays low until a later shift ends with release = 1.
- R9: A write to the transmit or command register while busy is ignored, and the word being shifted is not changed.
- R10: With the gate bit at 0, a command write with go set starts nothing.
- R11: While idle, sck_o follows pin-state bit 8 and mosi_o follows bit 0. cs_n_o[i] follows bit 16+i, except that a held chip select stays low.
- R12: Writes to the receive register have no effect on its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 3 | Active-low chip selects |
| miso_i | input | 1 | Serial data in |

## Verification
The busy flag is set by the clock edge that takes the command write. It stays set for 2·N·(D+1) cycles, so the bench reads the command register at each falling clock edge and counts the cycles in which bit 31 is 1. That count is compared with the formula. The chip-select level is checked at the first falling clock edge after the start. The captured output bits, the receive register and the released or held chip select are checked only after the busy count has ended. Register reads are combinational, so each readback and each pin level is sampled one time step after the falling clock edge. Values set by a write are checked at the falling edge that follows the write's rising edge.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int DIV_W   = 6;
    localparam int NUM_CS  = 3;
    localparam int CNT_W   = $clog2(DATA_W) + 1;

    localparam logic [ADDR_W-1:0] OFS_GATE = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RATE = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PINS = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_TXW  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_RXW  = 5'h18;

    localparam int CMD_GO_BIT  = 31;
    localparam int CMD_CS_LSB  = 28;
    localparam int CMD_END_BIT = 26;

    localparam int PIN_MOSI_BIT = 0;
    localparam int PIN_SCK_BIT  = 8;
    localparam int PIN_CS_LSB   = 16;
    localparam logic [DATA_W-1:0] PINS_RESET = 32'h0007_0000;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [NUM_CS-1:0] cs_sel;
        logic              release_cs;
        logic [CNT_W-1:0]  nbits;
    } xfer_req_t;

    function automatic xfer_req_t decode_cmd(input logic [DATA_W-1:0] w);
        xfer_req_t r;
        logic [CNT_W-1:0] c;
        r.cs_sel = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (w[CMD_CS_LSB + i]) begin
                r.cs_sel    = '0;
                r.cs_sel[i] = 1'b1;
            end
        end
        r.release_cs = w[CMD_END_BIT];
        c = w[CNT_W-1:0];
        if (c == '0 || c > CNT_W'(DATA_W)) r.nbits = CNT_W'(DATA_W);
        else                              r.nbits = c;
        return r;
    endfunction

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rx_word,
    output logic              gate_en,
    output logic [DIV_W-1:0]  div_val,
    output logic [DATA_W-1:0] pins_word,
    output logic [DATA_W-1:0] txw_word,
    output logic              start,
    output xfer_req_t         req
);

    logic [DATA_W-1:0] gate_q, rate_q, pins_q, txw_q, cmd_q;
    logic wr_hit;

    assign wr_hit = bus_en && bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            rate_q <= '0;
            pins_q <= PINS_RESET;
            txw_q  <= '0;
            cmd_q  <= '0;
        end else if (wr_hit) begin
            case (bus_addr)
                OFS_GATE: gate_q <= bus_wdata;
                OFS_RATE: rate_q <= bus_wdata;
                OFS_PINS: pins_q <= bus_wdata;
                OFS_TXW:  if (!busy) txw_q <= bus_wdata;
                OFS_CMD:  if (!busy) cmd_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign start = wr_hit && (bus_addr == OFS_CMD) && bus_wdata[CMD_GO_BIT]
                   && gate_q[0] && !busy;
    assign req   = decode_cmd(bus_wdata);

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_wr) begin
            case (bus_addr)
                OFS_GATE: bus_rdata = gate_q;
                OFS_RATE: bus_rdata = rate_q;
                OFS_PINS: bus_rdata = pins_q;
                OFS_TXW:  bus_rdata = txw_q;
                OFS_CMD:  bus_rdata = {busy, cmd_q[DATA_W-2:0]};
                OFS_RXW:  bus_rdata = rx_word;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign gate_en   = gate_q[0];
    assign div_val   = rate_q[DIV_W-1:0];
    assign pins_word = pins_q;
    assign txw_word  = txw_q;

endmodule

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_req_t         req,
    input  logic [DATA_W-1:0] txw,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              miso,
    output logic              busy,
    output logic              eng_sck,
    output logic              eng_mosi,
    output logic [NUM_CS-1:0] cs_drive,
    output logic [DATA_W-1:0] rx_word,
    output logic [DIV_W-1:0]  div_run
);

    eng_state_e        state_q;
    logic [DATA_W-1:0] sh_q, rx_q;
    logic [CNT_W-1:0]  left_q;
    logic [DIV_W-1:0]  div_q;
    logic [NUM_CS-1:0] cs_q, hold_q;
    logic              rel_q, tick;
    logic [CNT_W-1:0]  sh_amt;

    assign busy    = (state_q != ENG_IDLE);
    assign sh_amt  = CNT_W'(DATA_W) - req.nbits;
    assign div_run = div_q;

    spi_eng_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (start),
        .div     (div_q),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            sh_q    <= '0;
            rx_q    <= '0;
            left_q  <= '0;
            div_q   <= '0;
            cs_q    <= '0;
            hold_q  <= '0;
            rel_q   <= 1'b0;
        end else if (start) begin
            state_q <= ENG_LOW;
            sh_q    <= txw << sh_amt;
            rx_q    <= '0;
            left_q  <= req.nbits;
            div_q   <= div_in;
            cs_q    <= req.cs_sel;
            rel_q   <= req.release_cs;
            hold_q  <= '0;
        end else if (tick) begin
            case (state_q)
                ENG_LOW: begin
                    rx_q    <= {rx_q[DATA_W-2:0], miso};
                    state_q <= ENG_HIGH;
                end
                ENG_HIGH: begin
                    if (left_q == CNT_W'(1)) begin
                        state_q <= ENG_IDLE;
                        hold_q  <= rel_q ? '0 : cs_q;
                    end else begin
                        left_q  <= left_q - 1'b1;
                        sh_q    <= {sh_q[DATA_W-2:0], 1'b0};
                        state_q <= ENG_LOW;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign eng_sck  = (state_q == ENG_HIGH);
    assign eng_mosi = sh_q[DATA_W-1];
    assign cs_drive = busy ? cs_q : hold_q;
    assign rx_word  = rx_q;

endmodule

// File: rtl/spi_eng_pinmux.sv
module spi_eng_pinmux
    import spi_eng_pkg::*;
(
    input  logic              busy,
    input  logic              eng_sck,
    input  logic              eng_mosi,
    input  logic [NUM_CS-1:0] cs_drive,
    input  logic [DATA_W-1:0] pins,
    output logic              sck_o,
    output logic              mosi_o,
    output logic [NUM_CS-1:0] cs_n_o
);

    assign sck_o  = busy ? eng_sck  : pins[PIN_SCK_BIT];
    assign mosi_o = busy ? eng_mosi : pins[PIN_MOSI_BIT];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n_o[i] = pins[PIN_CS_LSB + i] & ~cs_drive[i];
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sck_o,
    output logic              mosi_o,
    output logic [NUM_CS-1:0] cs_n_o,
    input  logic              miso_i
);

    logic              eng_busy, gate_en, start, eng_sck, eng_mosi;
    logic [DIV_W-1:0]  div_val, div_run;
    logic [DATA_W-1:0] pins_word, txw_word, rx_word;
    logic [NUM_CS-1:0] cur_cs;
    xfer_req_t         req;

    spi_eng_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (eng_busy),
        .rx_word   (rx_word),
        .gate_en   (gate_en),
        .div_val   (div_val),
        .pins_word (pins_word),
        .txw_word  (txw_word),
        .start     (start),
        .req       (req)
    );

    spi_eng_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .txw      (txw_word),
        .div_in   (div_val),
        .miso     (miso_i),
        .busy     (eng_busy),
        .eng_sck  (eng_sck),
        .eng_mosi (eng_mosi),
        .cs_drive (cur_cs),
        .rx_word  (rx_word),
        .div_run  (div_run)
    );

    spi_eng_pinmux u_pins (
        .busy     (eng_busy),
        .eng_sck  (eng_sck),
        .eng_mosi (eng_mosi),
        .cs_drive (cur_cs),
        .pins     (pins_word),
        .sck_o    (sck_o),
        .mosi_o   (mosi_o),
        .cs_n_o   (cs_n_o)
    );

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk
    import spi_eng_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic              gate_en,
    input logic [DATA_W-1:0] txw_word,
    input logic              eng_sck,
    input logic              mosi_o,
    input logic [NUM_CS-1:0] cur_cs
);

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && bus_addr == OFS_CMD && bus_wdata[CMD_GO_BIT] && gate_en && !busy)
        |=> busy); // R3

    AST_TX_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(txw_word)); // R9

    AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_sck) |-> $stable(mosi_o)); // R6

    AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_sck); // R6

    AST_CS_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_cs)); // R8

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cur_cs)); // R8

endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (eng_busy),
    .gate_en   (gate_en),
    .txw_word  (txw_word),
    .eng_sck   (eng_sck),
    .mosi_o    (mosi_o),
    .cur_cs    (cur_cs)
);

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;

    localparam int CLK_P = 10;
    localparam logic [4:0] A_GATE = 5'h00, A_RATE = 5'h04, A_PINS = 5'h08,
                           A_TXW = 5'h10, A_CMD = 5'h14, A_RXW = 5'h18;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sck_o, mosi_o, miso_i = 1'b0;
    logic [2:0]  cs_n_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [31:0] slv_word = '0, mosi_cap = '0;
    int          slv_idx = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_shift_engine u_dut (
        .clk (clk), .rst (rst), .bus_en (bus_en), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .sck_o (sck_o), .mosi_o (mosi_o), .cs_n_o (cs_n_o), .miso_i (miso_i)
    );

    always @(negedge sck_o) begin
        if (slv_idx > 0) begin
            slv_idx = slv_idx - 1;
            miso_i  = slv_word[slv_idx];
        end
    end

    always @(posedge sck_o) mosi_cap = {mosi_cap[30:0], mosi_o};

    function automatic int eff_n(input logic [5:0] f);
        return (f == 0 || f > 32) ? 32 : int'(f);
    endfunction

    function automatic logic [31:0] nmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    endfunction

    function automatic logic [2:0] low_sel(input logic [2:0] raw);
        if (raw[0]) return 3'b001;
        if (raw[1]) return 3'b010;
        if (raw[2]) return 3'b100;
        return 3'b000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic [2:0] cs, input logic term,
                                             input logic [5:0] f);
        return {1'b1, cs, 1'b0, term, 20'd0, f};
    endfunction

    task automatic poll_busy(output int cyc);
        cyc = 0;
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = A_CMD;
        forever begin
            #1;
            if (!bus_rdata[31] || cyc > 20000) break;
            cyc++;
            @(negedge clk);
        end
        bus_en = 1'b0;
    endtask

    task automatic run_xfer(input logic [31:0] tx, input logic [5:0] f, input logic [2:0] cs,
                            input logic term, input logic [5:0] d, input logic [31:0] sw);
        int n, cyc;
        logic [31:0] rd;
        logic [2:0] sel;
        n   = eff_n(f);
        sel = low_sel(cs);
        bus_write(A_RATE, {26'd0, d});
        bus_write(A_TXW, tx);
        slv_word = sw; slv_idx = n - 1; miso_i = sw[n-1]; mosi_cap = '0;
        bus_write(A_CMD, cmd_word(cs, term, f));
        #1 check("R8 cs low during shift", {29'd0, cs_n_o}, {29'd0, ~sel});
        poll_busy(cyc);
        check("R4 busy cycles", cyc, 2 * n * (int'(d) + 1));
        check("R6 mosi bits", mosi_cap & nmask(n), tx & nmask(n));
        bus_read(A_RXW, rd);
        check("R7 rx word", rd, sw & nmask(n));
        #1 check("R8 cs after shift", {29'd0, cs_n_o}, {29'd0, term ? 3'b111 : ~sel});
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        bus_read(A_PINS, rd); check("R1 pins reset", rd, 32'h0007_0000);
        bus_read(A_CMD, rd);  check("R1 cmd reset", rd, 32'h0);
        bus_read(A_GATE, rd); check("R1 gate reset", rd, 32'h0);
        check("R1 idle pins", {29'd0, cs_n_o, sck_o, mosi_o} , {29'd0, 3'b111, 1'b0, 1'b0});

        // R10 gate closed: nothing starts
        bus_write(A_CMD, cmd_word(3'b001, 1'b1, 6'd8));
        bus_read(A_CMD, rd); check("R10 no start gate off", {31'd0, rd[31]}, 32'd0);
        check("R10 cs idle", {29'd0, cs_n_o}, 32'd7);

        // R2 readback
        bus_write(A_GATE, 32'h1);
        bus_write(A_RATE, 32'hABCD_0015);
        bus_read(A_RATE, rd); check("R2 rate readback", rd, 32'hABCD_0015);
        bus_read(5'h0C, rd);  check("R2 unmapped zero", rd, 32'h0);
        bus_write(A_TXW, 32'h1234_5678);
        bus_read(A_TXW, rd);  check("R2 tx readback", rd, 32'h1234_5678);

        // R12 receive is read-only
        bus_write(A_RXW, 32'hFFFF_FFFF);
        bus_read(A_RXW, rd);  check("R12 rx write ignored", rd, 32'h0);

        // R11 idle pin levels
        slv_idx = 0;
        bus_write(A_PINS, 32'h0007_0101);
        #1 check("R11 sck/mosi idle", {30'd0, sck_o, mosi_o}, 32'd3);
        bus_write(A_PINS, 32'h0003_0000);
        #1 check("R11 cs idle level", {29'd0, cs_n_o}, 32'd3);
        bus_write(A_PINS, 32'h0007_0000);

        // directed transfers
        run_xfer(32'h0000_00A5, 6'd8, 3'b001, 1'b1, 6'd0, 32'h0000_003C);      // R3 R6 R7
        run_xfer(32'hCAFE_F00D, 6'd0, 3'b010, 1'b1, 6'd1, 32'h8765_4321);      // R5 count 0
        run_xfer(32'h0F0F_5A5A, 6'd40, 3'b100, 1'b1, 6'd0, 32'h1357_9BDF);     // R5 count above 32
        run_xfer(32'h0000_0001, 6'd1, 3'b110, 1'b1, 6'd2, 32'h0000_0001);      // R8 priority
        run_xfer(32'h0000_BEEF, 6'd16, 3'b100, 1'b0, 6'd0, 32'h0000_1111);     // R8 hold
        bus_read(A_PINS, rd);
        #1 check("R8 held cs while idle", {29'd0, cs_n_o}, 32'd3);
        run_xfer(32'h0000_0055, 6'd8, 3'b100, 1'b1, 6'd0, 32'h0000_00AA);      // R8 release
        run_xfer(32'h0000_0002, 6'd2, 3'b001, 1'b1, 6'd63, 32'h0000_0003);     // R4 slowest

        // R9 writes while busy
        bus_write(A_RATE, 32'd3);
        bus_write(A_TXW, 32'h8000_0001);
        slv_word = 0; slv_idx = 31; miso_i = 1'b0; mosi_cap = '0;
        bus_write(A_CMD, cmd_word(3'b001, 1'b1, 6'd32));
        bus_write(A_TXW, 32'hDEAD_BEEF);
        bus_write(A_CMD, cmd_word(3'b100, 1'b0, 6'd4));
        poll_busy(cyc);
        bus_read(A_TXW, rd); check("R9 tx kept", rd, 32'h8000_0001);
        bus_read(A_CMD, rd); check("R9 cmd kept", rd, {1'b0, cmd_word(3'b001, 1'b1, 6'd32) & 32'h7FFF_FFFF});
        check("R9 shifted word intact", mosi_cap, 32'h8000_0001);

        // random mix
        for (int k = 0; k < 25; k++) begin
            logic [5:0] f, d;
            logic [2:0] cs;
            f  = 6'($urandom % 33);
            d  = 6'($urandom % 4);
            cs = 3'b001 << ($urandom % 3);
            run_xfer($urandom, f, cs, 1'($urandom % 2), d, $urandom);
        end
        run_xfer(32'h0, 6'd4, 3'b001, 1'b1, 6'd0, 32'h0);
        run_xfer(32'h0, 6'd4, 3'b010, 1'b1, 6'd0, 32'h0);
        run_xfer(32'h0, 6'd4, 3'b100, 1'b1, 6'd0, 32'h0);
        finish_up();
    end

endmodule